// File: doc/BRIEF.md
# ROM Image Integrity Checker

This block watches the byte stream of a device ROM image as it is fetched from a serial EEPROM and decides whether the image can be trusted. Each job starts with two length bytes, the 16-bit little-endian word stored at image offsets 14 and 15. The block reduces this word to a total image size. If the size is large enough, the block then takes the whole image from offset 0, one byte per accepted cycle.

While the bytes arrive, two checksum engines run. An 8-bit CRC covers the device identifier and a 32-bit Castagnoli CRC covers the payload that follows the fixed header. The block also captures the identifier, the revision byte and the header's own copy of the length field. One cycle after the last byte it posts a single verdict pulse. With that pulse come an error code, a valid flag, a revision warning, the computed size and the 64-bit identifier. These results hold until the next verdict. The surrounding logic fetches the bytes and acts on the verdict; this block only judges the image.

Top module: `rom_image_check`

## Requirements
- R1: While reset is held and after it is released, `done`, `img_ok`, `rev_warn` and `err_code` are all 0.
- R2: The first accepted byte of a job is the low byte and the second is the high byte of the length word. `img_size` is the word's bits 9:0 plus 13. Bits 15:10 of the word have no effect.
- R3: If the computed size is below 22, the block consumes no image bytes. It posts `err_code` 1 one cycle after the second length byte and returns to expecting a new length word.
- R4: `dev_uid` reports image bytes 1 to 8 as a little-endian value: byte 1 lands in bits 7:0 and byte 8 in bits 63:56.
- R5: Image byte 0 must equal the CRC-8 of bytes 1 to 8. This CRC uses polynomial 0x07, initial value 0xFF, MSB-first shifting, each byte XORed in before its eight shifts, and no final inversion. A mismatch gives `err_code` 3.
- R6: Bytes 9 to 12, read little-endian, must equal the reflected CRC-32C (polynomial 0x82F63B78 in reflected form, initial value all ones, final inversion) of image bytes 13 up to the last byte. A mismatch gives `err_code` 4.
- R7: The header's copy of the length field is bits 9:0 of the little-endian word at image bytes 14 and 15, plus 13. If it differs from the size taken from the length bytes, the result is `err_code` 2.
- R8: When several faults are present, the reported code follows the precedence 1, then 2, then 3, then 4. `img_ok` is 1 exactly when the posted code is 0.
- R9: A revision byte (image byte 13) above 1 sets `rev_warn` with the verdict and does not change `err_code` or `img_ok`.
- R10: `done` is a one-cycle pulse, one clock after the edge that takes the last byte of the job. All result outputs stay unchanged between verdicts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented on `in_byte` this cycle |
| in_byte | input | 8 | Length byte or image byte, in stream order |
| done | output | 1 | One-cycle verdict strobe |
| img_ok | output | 1 | Image accepted (error code 0) |
| rev_warn | output | 1 | Revision byte above the supported maximum |
| err_code | output | 3 | 0 ok, 1 too small, 2 size mismatch, 3 identifier CRC, 4 payload CRC |
| img_size | output | 11 | Total image size computed from the length bytes |
| dev_uid | output | 64 | Identifier taken from image bytes 1 to 8 |

## Verification
Every verdict is due exactly one clock after the edge that takes the job's final byte. For a short image, that final byte is the second length byte. The bench drops `in_valid` on the falling edge after that byte and first confirms that `done` is still low. It then samples all results on the next falling edge, where the pulse must be present, and on the one after, where it must be gone while the results hold. Faults are injected one per job, or two at once for the precedence cases, so the expected code follows directly from the stated encoding.

// File: rtl/rimg_pkg.sv
package rimg_pkg;

   typedef enum logic [2:0] {
      ERR_NONE  = 3'd0,
      ERR_SMALL = 3'd1,
      ERR_SIZE  = 3'd2,
      ERR_UID   = 3'd3,
      ERR_DATA  = 3'd4
   } rimg_err_e;

   typedef enum logic [1:0] {
      ST_LEN_LO,
      ST_LEN_HI,
      ST_IMAGE,
      ST_VERDICT
   } rimg_state_e;

endpackage

// File: rtl/rimg_len_unit.sv
module rimg_len_unit #(
   parameter int LEN_BITS   = 10,
   parameter int DATA_START = 13,
   parameter int SIZE_W     = LEN_BITS + 1
) (
   input  logic [7:0]          lo_byte,
   input  logic [LEN_BITS-9:0] hi_bits,
   output logic [SIZE_W-1:0]   size
);

   // the field is the word's low LEN_BITS bits; the offset of the payload
   // start is added to give the full image size
   assign size = SIZE_W'({hi_bits, lo_byte}) + SIZE_W'(DATA_START);

endmodule

// File: rtl/rimg_crc_acc.sv
module rimg_crc_acc #(
   parameter int           W       = 8,
   parameter logic [W-1:0] POLY    = W'(7),
   parameter logic [W-1:0] INIT    = '1,
   parameter bit           REFLECT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         en,
   input  logic [7:0]   din,
   output logic [W-1:0] crc
);

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_nxt;

   if (W < 8) begin : g_bad_w
      $error("rimg_crc_acc: W must be at least 8");
   end

   // generate picks the bit order: LSB-first (reflected) or MSB-first
   if (REFLECT) begin : g_lsb_first
      always_comb begin
         crc_nxt = crc_q ^ W'(din);
         for (int b = 0; b < 8; b++) begin
            crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ POLY) : (crc_nxt >> 1);
         end
      end
   end else begin : g_msb_first
      always_comb begin
         crc_nxt = crc_q ^ {din, {(W-8){1'b0}}};
         for (int b = 0; b < 8; b++) begin
            crc_nxt = crc_nxt[W-1] ? ((crc_nxt << 1) ^ POLY) : (crc_nxt << 1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         crc_q <= INIT;
      end else if (en) begin
         crc_q <= crc_nxt;
      end
   end

   assign crc = crc_q;

endmodule

// File: rtl/rom_image_check.sv
module rom_image_check #(
   parameter int LEN_BITS  = 10,
   parameter int UID_BYTES = 8,
   parameter int HDR_BYTES = 22,
   parameter int MAX_REV   = 1,
   parameter bit REV_WARN  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [7:0]             in_byte,
   output logic                   done,
   output logic                   img_ok,
   output logic                   rev_warn,
   output logic [2:0]             err_code,
   output logic [LEN_BITS:0]      img_size,
   output logic [UID_BYTES*8-1:0] dev_uid
);
   import rimg_pkg::*;

   localparam int SIZE_W     = LEN_BITS + 1;
   localparam int UID_W      = UID_BYTES * 8;
   localparam int DCRC_FIRST = UID_BYTES + 1;
   localparam int DATA_START = UID_BYTES + 5;
   localparam int REV_IDX    = DATA_START;
   localparam int LEN_IDX    = DATA_START + 1;

   localparam logic [SIZE_W-1:0] I_UCRC   = '0;
   localparam logic [SIZE_W-1:0] I_UID_LO = SIZE_W'(1);
   localparam logic [SIZE_W-1:0] I_UID_HI = SIZE_W'(UID_BYTES);
   localparam logic [SIZE_W-1:0] I_DC_LO  = SIZE_W'(DCRC_FIRST);
   localparam logic [SIZE_W-1:0] I_DATA   = SIZE_W'(DATA_START);
   localparam logic [SIZE_W-1:0] I_REV    = SIZE_W'(REV_IDX);
   localparam logic [SIZE_W-1:0] I_LEN_LO = SIZE_W'(LEN_IDX);
   localparam logic [SIZE_W-1:0] I_LEN_HI = SIZE_W'(LEN_IDX + 1);
   localparam logic [SIZE_W-1:0] MIN_SIZE = SIZE_W'(HDR_BYTES);

   if (LEN_BITS < 9 || LEN_BITS > 16) begin : g_bad_len
      $error("rom_image_check: LEN_BITS must be 9..16");
   end
   if (HDR_BYTES < LEN_IDX + 2) begin : g_bad_hdr
      $error("rom_image_check: HDR_BYTES must cover the length field");
   end
   if (DATA_START >= (1 << LEN_BITS)) begin : g_bad_start
      $error("rom_image_check: payload offset exceeds size range");
   end

   rimg_state_e      state_q;
   logic [SIZE_W-1:0] idx_q;
   logic [SIZE_W-1:0] size_q;
   logic [7:0]        len_lo_q;
   logic [7:0]        hdr_lo_q;
   logic [7:0]        ucrc_q;
   logic [31:0]       dcrc_q;
   logic [7:0]        rev_q;
   logic [UID_W-1:0]  uid_q;
   logic              small_q;
   logic              size_bad_q;

   logic [SIZE_W-1:0] size_early;
   logic [SIZE_W-1:0] size_hdr;
   logic [7:0]        crc8_v;
   logic [31:0]       crc32_v;
   logic              job_start;
   logic              take_img;
   logic              rev_high;
   rimg_err_e         err_nxt;

   assign job_start = (state_q == ST_LEN_LO) && in_valid;
   assign take_img  = (state_q == ST_IMAGE) && in_valid;

   rimg_len_unit #(.LEN_BITS(LEN_BITS), .DATA_START(DATA_START), .SIZE_W(SIZE_W))
      u_len_early (.lo_byte(len_lo_q), .hi_bits(in_byte[LEN_BITS-9:0]), .size(size_early));

   rimg_len_unit #(.LEN_BITS(LEN_BITS), .DATA_START(DATA_START), .SIZE_W(SIZE_W))
      u_len_hdr (.lo_byte(hdr_lo_q), .hi_bits(in_byte[LEN_BITS-9:0]), .size(size_hdr));

   rimg_crc_acc #(.W(8), .POLY(8'h07), .INIT(8'hFF), .REFLECT(1'b0)) u_crc8 (
      .clk(clk), .rst_n(rst_n), .clear(job_start),
      .en(take_img && idx_q >= I_UID_LO && idx_q <= I_UID_HI),
      .din(in_byte), .crc(crc8_v));

   rimg_crc_acc #(.W(32), .POLY(32'h82F6_3B78), .INIT(32'hFFFF_FFFF), .REFLECT(1'b1)) u_crc32 (
      .clk(clk), .rst_n(rst_n), .clear(job_start),
      .en(take_img && idx_q >= I_DATA),
      .din(in_byte), .crc(crc32_v));

   // variant: revision warning enabled or tied off
   if (REV_WARN) begin : g_rev
      assign rev_high = (rev_q > 8'(MAX_REV));
   end else begin : g_no_rev
      assign rev_high = 1'b0;
   end

   always_comb begin
      if (small_q)                       err_nxt = ERR_SMALL;
      else if (size_bad_q)               err_nxt = ERR_SIZE;
      else if (crc8_v != ucrc_q)         err_nxt = ERR_UID;
      else if (~crc32_v != dcrc_q)       err_nxt = ERR_DATA;
      else                               err_nxt = ERR_NONE;
   end

   // stream sequencing and header field capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_LEN_LO;
         idx_q      <= '0;
         size_q     <= '0;
         len_lo_q   <= '0;
         hdr_lo_q   <= '0;
         ucrc_q     <= '0;
         dcrc_q     <= '0;
         rev_q      <= '0;
         uid_q      <= '0;
         small_q    <= 1'b0;
         size_bad_q <= 1'b0;
      end else begin
         case (state_q)
            ST_LEN_LO: if (in_valid) begin
               len_lo_q   <= in_byte;
               small_q    <= 1'b0;
               size_bad_q <= 1'b0;
               rev_q      <= '0;
               state_q    <= ST_LEN_HI;
            end
            ST_LEN_HI: if (in_valid) begin
               size_q <= size_early;
               idx_q  <= '0;
               if (size_early < MIN_SIZE) begin
                  small_q <= 1'b1;
                  state_q <= ST_VERDICT;
               end else begin
                  state_q <= ST_IMAGE;
               end
            end
            ST_IMAGE: if (in_valid) begin
               if (idx_q == I_UCRC) ucrc_q <= in_byte;
               for (int k = 0; k < UID_BYTES; k++) begin
                  if (idx_q == I_UID_LO + SIZE_W'(k)) uid_q[k*8 +: 8] <= in_byte;
               end
               for (int k = 0; k < 4; k++) begin
                  if (idx_q == I_DC_LO + SIZE_W'(k)) dcrc_q[k*8 +: 8] <= in_byte;
               end
               if (idx_q == I_REV)    rev_q    <= in_byte;
               if (idx_q == I_LEN_LO) hdr_lo_q <= in_byte;
               if (idx_q == I_LEN_HI) size_bad_q <= (size_hdr != size_q);
               if (idx_q == size_q - SIZE_W'(1)) state_q <= ST_VERDICT;
               idx_q <= idx_q + SIZE_W'(1);
            end
            default: state_q <= ST_LEN_LO;
         endcase
      end
   end

   // verdict registers, updated only in the cycle after the last byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         img_ok   <= 1'b0;
         rev_warn <= 1'b0;
         err_code <= '0;
         img_size <= '0;
         dev_uid  <= '0;
      end else begin
         done <= (state_q == ST_VERDICT);
         if (state_q == ST_VERDICT) begin
            err_code <= err_nxt;
            img_ok   <= (err_nxt == ERR_NONE);
            rev_warn <= !small_q && rev_high;
            img_size <= size_q;
            dev_uid  <= uid_q;
         end
      end
   end

endmodule

// File: rtl/rimg_chk.sv
module rimg_chk #(
   parameter int LEN_BITS  = 10,
   parameter int HDR_BYTES = 22
) (
   input logic                clk,
   input logic                rst_n,
   input logic                done,
   input logic                img_ok,
   input logic                rev_warn,
   input logic [2:0]          err_code,
   input logic [LEN_BITS:0]   img_size
);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(err_code) && $stable(img_ok) && $stable(rev_warn) && $stable(img_size)));

   a_r3_small_code: assert property (@(posedge clk) disable iff (!rst_n)
      (done && img_size < (LEN_BITS+1)'(HDR_BYTES)) |-> (err_code == 3'd1));

   a_r3_code_means_small: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code == 3'd1) |-> (img_size < (LEN_BITS+1)'(HDR_BYTES)));

   a_r8_ok_iff_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (img_ok == (err_code == 3'd0)));

   a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      err_code <= 3'd4);

endmodule

bind rom_image_check rimg_chk #(.LEN_BITS(LEN_BITS), .HDR_BYTES(HDR_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .img_ok(img_ok),
   .rev_warn(rev_warn), .err_code(err_code), .img_size(img_size));

// File: tb/sim_rom_image_check.sv
`timescale 1ns/1ps
module sim_rom_image_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        done, img_ok, rev_warn;
   logic [2:0]  err_code;
   logic [10:0] img_size;
   logic [63:0] dev_uid;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic [7:0] img [0:1100];

   always #4 clk = ~clk;

   rom_image_check u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .done(done), .img_ok(img_ok), .rev_warn(rev_warn), .err_code(err_code),
      .img_size(img_size), .dev_uid(dev_uid));

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m_crc8();
      logic [7:0] c = 8'hFF;
      for (int i = 1; i <= 8; i++) begin
         c = c ^ img[i];
         for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [31:0] m_crc32(int first, int last);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = first; i <= last; i++) begin
         c = c ^ {24'h0, img[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
      end
      return ~c;
   endfunction

   // well-formed image of n bytes
   task automatic build(int n, logic [7:0] rev, logic [63:0] id);
      logic [31:0] dc;
      for (int i = 0; i < n; i++) img[i] = 8'((i * 37 + 11) ^ (i >> 3));
      for (int k = 0; k < 8; k++) img[1+k] = id[k*8 +: 8];
      img[13] = rev;
      img[14] = 8'(n - 13);
      img[15] = {6'b0, 2'((n - 13) >> 8)};
      img[0]  = m_crc8();
      dc = m_crc32(13, n - 1);
      for (int k = 0; k < 4; k++) img[9+k] = dc[k*8 +: 8];
   endtask

   // length bytes then n image bytes; returns at the verdict sample point
   task automatic send(logic [7:0] lo, logic [7:0] hi, int n, string req);
      @(negedge clk); in_valid = 1'b1; in_byte = lo;
      @(negedge clk); in_byte = hi;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_byte = img[i];
      end
      @(negedge clk); in_valid = 1'b0;
      chk({req, " R10 no early done"}, 64'(done), 64'd0);
      @(negedge clk);
      chk({req, " R10 done due"}, 64'(done), 64'd1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 done in reset", 64'(done), 64'd0);
      chk("R1 ok in reset", 64'(img_ok), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 err after reset", 64'(err_code), 64'd0);
      chk("R1 warn after reset", 64'(rev_warn), 64'd0);
   endtask

   task automatic t_min_good();
      build(22, 8'd0, 64'h0123_4567_89AB_CDEF);
      send(8'd9, 8'd0, 22, "min");
      chk("R6 min ok", 64'(img_ok), 64'd1);
      chk("R6 min code", 64'(err_code), 64'd0);
      chk("R2 min size", 64'(img_size), 64'd22);
      chk("R4 uid", dev_uid, 64'h0123_4567_89AB_CDEF);
      chk("R9 rev0 no warn", 64'(rev_warn), 64'd0);
      @(negedge clk);
      chk("R10 pulse ends", 64'(done), 64'd0);
   endtask

   task automatic t_upper_bits();
      // 300 bytes: field 287 = 0x11F; high length byte carries junk in bits 15:10
      build(300, 8'd1, 64'hFEDC_BA98_7654_3210);
      send(8'h1F, 8'hFD, 300, "upper");
      chk("R2 upper bits ignored size", 64'(img_size), 64'd300);
      chk("R2 upper bits ignored code", 64'(err_code), 64'd0);
      chk("R9 rev1 no warn", 64'(rev_warn), 64'd0);
      chk("R4 uid big", dev_uid, 64'hFEDC_BA98_7654_3210);
   endtask

   task automatic t_rev_warn();
      build(50, 8'd2, 64'h1111_2222_3333_4444);
      send(8'd37, 8'd0, 50, "rev");
      chk("R9 rev2 warn", 64'(rev_warn), 64'd1);
      chk("R9 rev2 still ok", 64'(img_ok), 64'd1);
      chk("R9 rev2 code", 64'(err_code), 64'd0);
   endtask

   task automatic t_uid_bad();
      build(22, 8'd0, 64'hA5A5_5A5A_0F0F_F0F0);
      img[0] = img[0] ^ 8'h01;
      send(8'd9, 8'd0, 22, "uid");
      chk("R5 uid crc code", 64'(err_code), 64'd3);
      chk("R8 uid crc not ok", 64'(img_ok), 64'd0);
   endtask

   task automatic t_data_bad();
      build(40, 8'd0, 64'h0000_0000_0000_0001);
      img[39] = img[39] ^ 8'h80;
      send(8'd27, 8'd0, 40, "data");
      chk("R6 payload crc code", 64'(err_code), 64'd4);
      chk("R6 payload crc not ok", 64'(img_ok), 64'd0);
   endtask

   task automatic t_mismatch();
      // length bytes say 30, header field says 31, identifier CRC also broken
      build(31, 8'd0, 64'h7777_0000_7777_0000);
      img[0] = img[0] ^ 8'hFF;
      send(8'd17, 8'd0, 30, "mismatch");
      chk("R7 size mismatch code", 64'(err_code), 64'd2);
      chk("R8 mismatch beats uid crc", 64'(img_ok), 64'd0);
      chk("R2 size from length bytes", 64'(img_size), 64'd30);
   endtask

   task automatic t_small();
      send(8'd8, 8'd0, 0, "small");
      chk("R3 too small code", 64'(err_code), 64'd1);
      chk("R3 too small size", 64'(img_size), 64'd21);
      chk("R3 too small not ok", 64'(img_ok), 64'd0);
      // the block must expect a fresh length word right away
      build(22, 8'd0, 64'h5555_6666_7777_8888);
      send(8'd9, 8'd0, 22, "after small");
      chk("R3 next job ok", 64'(err_code), 64'd0);
   endtask

   task automatic t_hold();
      repeat (6) @(negedge clk);
      chk("R10 hold code", 64'(err_code), 64'd0);
      chk("R10 hold size", 64'(img_size), 64'd22);
      chk("R10 hold uid", dev_uid, 64'h5555_6666_7777_8888);
      chk("R10 no stray done", 64'(done), 64'd0);
   endtask

   initial begin
      t_reset();
      t_min_good();
      t_upper_bits();
      t_rev_warn();
      t_uid_bad();
      t_data_bad();
      t_mismatch();
      t_small();
      t_hold();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule